// File: doc/BRIEF.md
# Flash Command-State Interface Controller

This block sits between a small microcontroller bus and an embedded flash array and keeps track of the mode the array interface is in. It merges several reset requests into one active-low interface reset. While that reset is held, the interface stays in a low-power standby mode. When the reset is released, the interface moves to read-array mode.

It holds a write-only command register that has no bus address. The register is loaded by a bus cycle in which the active-low chip-enable and write-enable strobes are both low. An example two-cycle command takes one argument write and then runs a busy phase whose length comes from the argument byte. Writes that arrive during standby, during the busy phase, or as the argument of a command never reach the command register. The block also splits the 16-bit bus address into page, row and byte fields for the array.

All inputs are sampled on one clock. A reset request that arrives during the busy phase aborts the operation on the same edge.

Top module: `flash_mode_ctrl`

## Requirements
- R1: `flashRstN` goes low on the first clock edge that samples any of these conditions, and stays low while any of them holds: `porReq` high, `extAccessN` low, `codeFetch` high together with `cpuIdle` or `cpuSleep` high, or `flashRstBit` high. Idle or sleep without `codeFetch` has no effect.
- R2: A 1-to-0 transition of `testPgm` on its own pulls `flashRstN` low for exactly one clock. The mode then passes through standby and returns to read-array.
- R3: On the edge where a reset request is sampled, `mode` becomes standby (code 0), `busy` becomes 0 and `arrayEn` becomes 0. This also holds when the request arrives during the busy phase, which aborts the operation.
- R4: `mode` changes from standby to read-array (code 1) one clock after `flashRstN` returns high.
- R5: `cmdValue` is 8'hFF after any reset.
- R6: In read-array mode, a write is taken once, on the first edge at which `ceN` and `weN` are both sampled low. The byte is visible on `cmdValue` after that edge. Data that changes while the strobes stay low is not taken again. Code 8'hFF and codes other than 8'h40 are stored and leave the mode at read-array.
- R7: Code 8'h40 moves `mode` to the argument state (code 2). The next write is an argument and is not stored. It moves `mode` to busy (code 3) with `busy` high for (argument + 1) clocks, after which `mode` returns to read-array.
- R8: Writes taken during the busy phase change neither `cmdValue` nor `mode`.
- R9: Writes during standby are ignored, so `cmdValue` remains 8'hFF.
- R10: `pageNum` = `busAddr[15:9]`, `rowNum` = `busAddr[8:6]` and `byteNum` = `busAddr[5:0]`, all combinational with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| porReq | input | 1 | Power-on reset request, active high |
| extAccessN | input | 1 | External-access pin, low requests reset |
| cpuIdle | input | 1 | Processor idle indication |
| cpuSleep | input | 1 | Processor sleep indication |
| codeFetch | input | 1 | Processor is fetching code from the flash |
| flashRstBit | input | 1 | Software reset-flash control bit |
| testPgm | input | 1 | Test-programming pin, falling edge pulses reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| busData | input | 8 | Write data byte |
| busAddr | input | 16 | Bus address |
| flashRstN | output | 1 | Merged interface reset, active low |
| mode | output | 2 | 0 standby, 1 read-array, 2 argument, 3 busy |
| busy | output | 1 | Busy phase in progress |
| arrayEn | output | 1 | Array and processor port enabled |
| cmdValue | output | 8 | Current command register contents |
| pageNum | output | 7 | Page field of busAddr |
| rowNum | output | 3 | Row field of busAddr |
| byteNum | output | 6 | Byte field of busAddr |

## Verification
Reset-request effects on `flashRstN`, `mode`, `busy` and `cmdValue`, and accepted writes, appear one edge after they are sampled. The move from standby to read-array comes one edge later still. The busy phase ends (argument + 1) edges after the argument edge, and the address fields need no clock edge at all. The driver drives inputs at the falling edge and queues the values due after the next rising edge. The monitor samples 2 ns after each rising edge, so every clocked result is compared in the cycle it is due, and the address fields are checked after a short settling delay.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_ARG     = 2'd2,
    MODE_BUSY    = 2'd3
  } fmcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic loadCmd;
    logic loadCnt;
    logic decCnt;
  } fmcStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_TWO_CYCLE  = 8'h40;

endpackage

// File: rtl/fmc_rst_merge.sv
module fmc_rst_merge (
  input  logic clk,
  input  logic porReq,
  input  logic extAccessN,
  input  logic cpuIdle,
  input  logic cpuSleep,
  input  logic codeFetch,
  input  logic flashRstBit,
  input  logic testPgm,
  output logic rstReq,
  output logic flashRstN
);

  logic pgmQ;
  logic pgmFell;
  logic fetchStall;

  always_ff @(posedge clk) begin
    pgmQ <= testPgm;
  end

  assign pgmFell    = pgmQ & ~testPgm;
  assign fetchStall = codeFetch & (cpuIdle | cpuSleep);
  assign rstReq     = porReq | ~extAccessN | fetchStall | flashRstBit | pgmFell;

  always_ff @(posedge clk) begin
    flashRstN <= ~rstReq;
  end

  // R1: every non-power-on source pulls the reset low on the next edge
  a_r1_source_resets: assert property (@(posedge clk) disable iff (porReq)
    (!extAccessN || flashRstBit || (codeFetch && (cpuIdle || cpuSleep))) |=> !flashRstN);

  // R2: a falling test pin pulses the reset
  a_r2_pgm_pulse: assert property (@(posedge clk) disable iff (porReq)
    $fell(testPgm) |=> !flashRstN);

endmodule

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
  import fmc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              rstReq,
  input  logic              flashRstN,
  input  logic              wrTake,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntZero,
  output fmcMode_e          mode,
  output fmcStrobe_t        strobe
);

  fmcMode_e modeQ;
  fmcMode_e modeNext;

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_STANDBY: if (flashRstN) modeNext = MODE_READ;
      MODE_READ: begin
        if (wrTake && wrData == DATA_W'(CMD_TWO_CYCLE)) modeNext = MODE_ARG;
        else if (wrTake && wrData == DATA_W'(CMD_READ_ARRAY)) modeNext = MODE_READ;
      end
      MODE_ARG:  if (wrTake) modeNext = MODE_BUSY;
      MODE_BUSY: if (cntZero) modeNext = MODE_READ;
      default:   modeNext = MODE_STANDBY;
    endcase
    if (rstReq) modeNext = MODE_STANDBY;
  end

  always_ff @(posedge clk) begin
    modeQ <= modeNext;
  end

  always_comb begin
    strobe.clearAll = rstReq;
    strobe.loadCmd  = !rstReq && modeQ == MODE_READ && wrTake;
    strobe.loadCnt  = !rstReq && modeQ == MODE_ARG && wrTake;
    strobe.decCnt   = !rstReq && modeQ == MODE_BUSY && !cntZero;
  end

  assign mode = modeQ;

  // R3: any reset request lands the mode in standby on the next edge
  a_r3_standby_on_req: assert property (@(posedge clk) disable iff (porReq)
    rstReq |=> modeQ == MODE_STANDBY);

  // R4: release leads to read-array one edge after the reset rises
  a_r4_release_read: assert property (@(posedge clk) disable iff (porReq)
    (modeQ == MODE_STANDBY && flashRstN && !rstReq) |=> modeQ == MODE_READ);

  // R7: an expired busy count returns to read-array
  a_r7_busy_exit: assert property (@(posedge clk) disable iff (porReq)
    (modeQ == MODE_BUSY && cntZero && !rstReq) |=> modeQ == MODE_READ);

endmodule

// File: rtl/fmc_datapath.sv
module fmc_datapath
  import fmc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 3,
  parameter int BYTE_W = 6,
  localparam int PAGE_W = ADDR_W - ROW_W - BYTE_W
) (
  input  logic              clk,
  input  logic              porReq,
  input  fmcStrobe_t        strobe,
  input  logic              ceN,
  input  logic              weN,
  input  logic [DATA_W-1:0] busData,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              wrTake,
  output logic [DATA_W-1:0] wrData,
  output logic              cntZero,
  output logic [DATA_W-1:0] cmdValue,
  output logic [PAGE_W-1:0] pageNum,
  output logic [ROW_W-1:0]  rowNum,
  output logic [BYTE_W-1:0] byteNum
);

  localparam logic [DATA_W-1:0] CMD_RESET_VAL = {DATA_W{1'b1}};

  logic              bothLow;
  logic              wrUsed;
  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] cntQ;

  assign bothLow = !ceN && !weN;
  assign wrTake  = bothLow && !wrUsed;
  assign wrData  = busData;

  // one acceptance per strobe assertion
  always_ff @(posedge clk) begin
    if (strobe.clearAll) wrUsed <= 1'b0;
    else                 wrUsed <= bothLow;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll)     cmdQ <= CMD_RESET_VAL;
    else if (strobe.loadCmd) cmdQ <= busData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll)     cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= busData;
    else if (strobe.decCnt)  cntQ <= cntQ - 1'b1;
  end

  assign cntZero  = (cntQ == '0);
  assign cmdValue = cmdQ;

  assign byteNum = busAddr[BYTE_W-1:0];
  assign rowNum  = busAddr[BYTE_W +: ROW_W];
  assign pageNum = busAddr[ADDR_W-1 -: PAGE_W];

  // R6: a held write is taken only once
  a_r6_single_take: assert property (@(posedge clk) disable iff (porReq)
    (wrTake && !strobe.clearAll) |=> !wrTake);

  // R5: command register returns to all ones after a reset request
  a_r5_cmd_reset: assert property (@(posedge clk) disable iff (porReq)
    strobe.clearAll |=> cmdQ == CMD_RESET_VAL);

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 3,
  parameter int BYTE_W = 6,
  localparam int PAGE_W = ADDR_W - ROW_W - BYTE_W
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              extAccessN,
  input  logic              cpuIdle,
  input  logic              cpuSleep,
  input  logic              codeFetch,
  input  logic              flashRstBit,
  input  logic              testPgm,
  input  logic              ceN,
  input  logic              weN,
  input  logic [DATA_W-1:0] busData,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              flashRstN,
  output logic [1:0]        mode,
  output logic              busy,
  output logic              arrayEn,
  output logic [DATA_W-1:0] cmdValue,
  output logic [PAGE_W-1:0] pageNum,
  output logic [ROW_W-1:0]  rowNum,
  output logic [BYTE_W-1:0] byteNum
);

  logic              rstReq;
  logic              wrTake;
  logic [DATA_W-1:0] wrData;
  logic              cntZero;
  fmcMode_e          modeCur;
  fmcStrobe_t        strobe;

  fmc_rst_merge u_rst (
    .clk        (clk),
    .porReq     (porReq),
    .extAccessN (extAccessN),
    .cpuIdle    (cpuIdle),
    .cpuSleep   (cpuSleep),
    .codeFetch  (codeFetch),
    .flashRstBit(flashRstBit),
    .testPgm    (testPgm),
    .rstReq     (rstReq),
    .flashRstN  (flashRstN)
  );

  fmc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .porReq   (porReq),
    .rstReq   (rstReq),
    .flashRstN(flashRstN),
    .wrTake   (wrTake),
    .wrData   (wrData),
    .cntZero  (cntZero),
    .mode     (modeCur),
    .strobe   (strobe)
  );

  fmc_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk     (clk),
    .porReq  (porReq),
    .strobe  (strobe),
    .ceN     (ceN),
    .weN     (weN),
    .busData (busData),
    .busAddr (busAddr),
    .wrTake  (wrTake),
    .wrData  (wrData),
    .cntZero (cntZero),
    .cmdValue(cmdValue),
    .pageNum (pageNum),
    .rowNum  (rowNum),
    .byteNum (byteNum)
  );

  assign mode    = modeCur;
  assign busy    = (modeCur == MODE_BUSY);
  assign arrayEn = (modeCur != MODE_STANDBY);

  // R8: the command register holds through the busy phase
  a_r8_busy_cmd_stable: assert property (@(posedge clk) disable iff (porReq)
    (busy && !rstReq) |=> $stable(cmdValue));

  // R9: nothing is loaded from standby
  a_r9_standby_no_load: assert property (@(posedge clk) disable iff (porReq)
    (modeCur == MODE_STANDBY) |=> cmdValue == {DATA_W{1'b1}});

endmodule

// File: tb/flash_mode_ctrl_bench.sv
`timescale 1ns/1ps
module flash_mode_ctrl_bench;

  logic clk = 1'b0;
  logic porReq = 1'b1;
  logic extAccessN = 1'b1;
  logic cpuIdle = 1'b0;
  logic cpuSleep = 1'b0;
  logic codeFetch = 1'b0;
  logic flashRstBit = 1'b0;
  logic testPgm = 1'b0;
  logic ceN = 1'b1;
  logic weN = 1'b1;
  logic [7:0]  busData = 8'h00;
  logic [15:0] busAddr = 16'h0000;
  logic        flashRstN;
  logic [1:0]  mode;
  logic        busy;
  logic        arrayEn;
  logic [7:0]  cmdValue;
  logic [6:0]  pageNum;
  logic [2:0]  rowNum;
  logic [5:0]  byteNum;

  int nChecks = 0;
  int nFails  = 0;
  string       tagQ[$];
  logic [12:0] expQ[$];

  localparam logic [1:0] M_STB = 2'd0, M_RD = 2'd1, M_ARG = 2'd2, M_BSY = 2'd3;

  always #4 clk = ~clk;

  flash_mode_ctrl u_flash_mode_ctrl (
    .clk(clk), .porReq(porReq), .extAccessN(extAccessN), .cpuIdle(cpuIdle),
    .cpuSleep(cpuSleep), .codeFetch(codeFetch), .flashRstBit(flashRstBit),
    .testPgm(testPgm), .ceN(ceN), .weN(weN), .busData(busData), .busAddr(busAddr),
    .flashRstN(flashRstN), .mode(mode), .busy(busy), .arrayEn(arrayEn),
    .cmdValue(cmdValue), .pageNum(pageNum), .rowNum(rowNum), .byteNum(byteNum)
  );

  // driver: queue what is due after the coming rising edge, then move on
  task automatic tick(input string tag, input logic [1:0] m, input logic [7:0] c,
                      input logic r);
    tagQ.push_back(tag);
    expQ.push_back({r, (m == M_BSY), (m != M_STB), m, c});
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        string       t;
        logic [12:0] e;
        logic [12:0] a;
        t = tagQ.pop_front();
        e = expQ.pop_front();
        a = {flashRstN, busy, arrayEn, mode, cmdValue};
        nChecks++;
        if (a !== e) begin
          nFails++;
          $display("FAIL %s: rstN/busy/en/mode/cmd actual %b/%b/%b/%0d/%h expected %b/%b/%b/%0d/%h",
                   t, a[12], a[11], a[10], a[9:8], a[7:0], e[12], e[11], e[10], e[9:8], e[7:0]);
        end
      end
    end
  end

  task automatic chkAddr(input logic [15:0] a);
    busAddr = a;
    #1;
    nChecks++;
    if (pageNum !== 7'(a / 512) || rowNum !== 3'((a / 64) % 8) || byteNum !== 6'(a % 64)) begin
      nFails++;
      $display("FAIL R10: addr %h actual %h/%h/%h expected %h/%h/%h", a, pageNum, rowNum,
               byteNum, 7'(a / 512), 3'((a / 64) % 8), 6'(a % 64));
    end
  endtask

  task automatic wrOn(input logic [7:0] d);
    ceN = 1'b0; weN = 1'b0; busData = d;
  endtask

  task automatic wrOff();
    ceN = 1'b1; weN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 R5: power-on request holds reset, register at FF
    tick("R1", M_STB, 8'hFF, 1'b0);
    tick("R5", M_STB, 8'hFF, 1'b0);
    porReq = 1'b0;
    tick("R4", M_STB, 8'hFF, 1'b1);
    tick("R4", M_RD,  8'hFF, 1'b1);

    // R6: one write, held strobes with changing data
    wrOn(8'h12);
    tick("R6", M_RD, 8'h12, 1'b1);
    busData = 8'h34;
    tick("R6", M_RD, 8'h12, 1'b1);
    wrOff();
    tick("R6", M_RD, 8'h12, 1'b1);
    wrOn(8'hFF);
    tick("R6", M_RD, 8'hFF, 1'b1);
    wrOff();
    tick("R6", M_RD, 8'hFF, 1'b1);

    // R7: two-cycle command, argument 3 -> busy for 4 clocks
    wrOn(8'h40);
    tick("R7", M_ARG, 8'h40, 1'b1);
    wrOff();
    tick("R7", M_ARG, 8'h40, 1'b1);
    wrOn(8'h03);
    tick("R7", M_BSY, 8'h40, 1'b1);
    wrOff();
    tick("R7", M_BSY, 8'h40, 1'b1);
    wrOn(8'h55);
    tick("R8", M_BSY, 8'h40, 1'b1);
    wrOff();
    tick("R8", M_BSY, 8'h40, 1'b1);
    tick("R7", M_RD,  8'h40, 1'b1);

    // R3: reset during busy aborts
    wrOn(8'h40);
    tick("R7", M_ARG, 8'h40, 1'b1);
    wrOff();
    tick("R7", M_ARG, 8'h40, 1'b1);
    wrOn(8'h0A);
    tick("R7", M_BSY, 8'h40, 1'b1);
    wrOff();
    tick("R7", M_BSY, 8'h40, 1'b1);
    extAccessN = 1'b0;
    tick("R3", M_STB, 8'hFF, 1'b0);
    tick("R3", M_STB, 8'hFF, 1'b0);
    extAccessN = 1'b1;
    tick("R4", M_STB, 8'hFF, 1'b1);
    tick("R4", M_RD,  8'hFF, 1'b1);

    // R1: idle or sleep only matter in code fetch
    codeFetch = 1'b1;
    tick("R1", M_RD,  8'hFF, 1'b1);
    cpuIdle = 1'b1;
    tick("R1", M_STB, 8'hFF, 1'b0);
    cpuIdle = 1'b0; cpuSleep = 1'b1;
    tick("R1", M_STB, 8'hFF, 1'b0);
    cpuSleep = 1'b0;
    tick("R1", M_STB, 8'hFF, 1'b1);
    tick("R1", M_RD,  8'hFF, 1'b1);
    codeFetch = 1'b0; cpuSleep = 1'b1; cpuIdle = 1'b1;
    tick("R1", M_RD,  8'hFF, 1'b1);
    cpuSleep = 1'b0; cpuIdle = 1'b0;

    // R1 R9: control bit reset, write during standby ignored
    flashRstBit = 1'b1;
    tick("R1", M_STB, 8'hFF, 1'b0);
    wrOn(8'h22);
    tick("R9", M_STB, 8'hFF, 1'b0);
    wrOff();
    tick("R9", M_STB, 8'hFF, 1'b0);
    flashRstBit = 1'b0;
    tick("R9", M_STB, 8'hFF, 1'b1);
    tick("R9", M_RD,  8'hFF, 1'b1);

    // R2: test pin falling edge pulses reset
    testPgm = 1'b1;
    tick("R2", M_RD,  8'hFF, 1'b1);
    testPgm = 1'b0;
    tick("R2", M_STB, 8'hFF, 1'b0);
    tick("R2", M_STB, 8'hFF, 1'b1);
    tick("R2", M_RD,  8'hFF, 1'b1);

    // R10: address split
    chkAddr(16'hABCD);
    chkAddr(16'h0000);
    chkAddr(16'hFFFF);
    chkAddr(16'h0240);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule